// File: doc/BRIEF.md
# Call-Injecting Interrupt Controller

This block sits on the bus of an 8-bit CPU that has separate M1, IORQ, MREQ, RD and WR strobes, and manages eight interrupt request lines. A rising edge on a request line records it as pending. When a pending input is also enabled, the block pulls its active-low interrupt line down. When the CPU acknowledges, the block does not return a single restart byte. It supplies a complete three-byte subroutine call instead, so each input can branch straight to its own 16-bit handler address. Software loads those addresses through I/O writes.

The opcode byte goes out during the acknowledge cycle, which is M1 and IORQ low together. The CPU fetches the two operand bytes with ordinary memory reads. For that reason the block keeps a service flag from the acknowledge until the next opcode fetch. It answers the first two memory reads after the acknowledge with the low and then the high byte of the handler address. While those reads are pending it raises an inhibit output, which shuts off the memory bus buffers. The block samples the bus strobes on its own clock, and every output comes from a register, so each output follows its cause by one clock.

Top module: `call_irq_ctrl`

## Requirements
- R1: After a synchronous reset the outputs are as follows: int_n is high, dout_en and mem_inhibit are low, and no input is pending or enabled.
- R2: A rising edge on irq_in[i] makes input i pending. When a pending and enabled input exists and no service is in progress, int_n is low one clock later.
- R3: An I/O write to port PORT_BASE+16 loads the enable mask, where bit i enables input i. A disabled input stays pending but does not pull int_n low. It is signalled once it is enabled.
- R4: Priority is fixed, and a lower input index wins over a higher one.
- R5: An acknowledge is M1 and IORQ both low. One clock after its first sampled cycle, dout holds CD hex with dout_en high, and they stay that way for the rest of the acknowledge.
- R6: The first memory read after the acknowledge (MREQ and RD low, M1 high) is driven with the low byte of the selected handler address. The second is driven with the high byte. dout_en is low between the reads.
- R7: mem_inhibit is high from the end of the acknowledge until the end of the second address read. It is low during the acknowledge and at all other times.
- R8: The input to serve is chosen at the start of the acknowledge. Requests that arrive later do not change the bytes supplied.
- R9: The served input stops being pending when its second address read ends. A new rising edge on that same input in that same clock keeps it pending.
- R10: The service flag is cleared by the next opcode fetch (M1 and MREQ low). Until then, int_n stays high, and memory writes such as stack pushes are neither driven nor inhibited.
- R11: One I/O write (IORQ and WR low, M1 high) to port PORT_BASE+2i loads the low byte of handler i, and a write to PORT_BASE+2i+1 loads its high byte. Each write touches only the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to sample the bus strobes |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Request lines, taken on rising edge |
| addr | input | 16 | CPU address bus; bits 7:0 select the I/O port |
| din | input | 8 | CPU write data |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| int_n | output | 1 | Interrupt request to the CPU, active low |
| dout | output | 8 | Byte supplied to the CPU data bus |
| dout_en | output | 1 | Drive enable for dout |
| mem_inhibit | output | 1 | Disables the memory bus buffers while address bytes are injected |

## Verification
Two events can fall in the same clock: the clearing of the served input's pending bit at the end of the second address read, and a new rising edge on that same input. The bench causes this by raising the served line in exactly the cycle that releases the second read. It then counts the case correct only if int_n falls again after the opcode fetch and a second acknowledge delivers that input's handler. A related test raises a higher-priority line between the acknowledge and the address reads. It expects the bytes already chosen to be delivered unchanged, and the new request to be served next.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam logic [7:0] CALL_OP = 8'hCD;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_WLO,
    ST_RLO,
    ST_WHI,
    ST_RHI,
    ST_WFETCH
  } seq_st_t;
endpackage

// File: rtl/cic_req_bank.sv
module cic_req_bank #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_i,
  input  logic          en_we,
  input  logic [N-1:0]  en_wdata,
  input  logic [N-1:0]  clr_i,
  output logic          req_any,
  output logic [IW-1:0] req_idx
);
  logic [N-1:0] irq_q, pend_q, en_q, pend_d, rise, elig;

  assign rise   = irq_i & ~irq_q;
  assign pend_d = (pend_q & ~clr_i) | rise;
  assign elig   = pend_d & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= pend_d;
      if (en_we) en_q <= en_wdata;
    end
  end

  always_comb begin
    req_any = 1'b0;
    req_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        req_any = 1'b1;
        req_idx = IW'(i);
      end
    end
  end

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & rise)) |=> (|(pend_q & $past(clr_i))));

  // R9
  clear_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_i));
endmodule

// File: rtl/cic_vec_regs.sv
module cic_vec_regs #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          we_hi,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rd_lo,
  output logic [7:0]    rd_hi
);
  logic [7:0] lo_mem [N];
  logic [7:0] hi_mem [N];

  always_ff @(posedge clk) begin
    if (we && !we_hi) lo_mem[widx] <= wdata;
    rd_lo <= lo_mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (we && we_hi) hi_mem[widx] <= wdata;
    rd_hi <= hi_mem[ridx];
  end
endmodule

// File: rtl/cic_ack_seq.sv
module cic_ack_seq
  import cic_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_c,
  input  logic          mrd_c,
  input  logic          fetch_c,
  input  logic          req_any,
  input  logic [IW-1:0] req_idx,
  input  logic [7:0]    vec_lo,
  input  logic [7:0]    vec_hi,
  output logic [IW-1:0] sel_idx,
  output logic [N-1:0]  clr_o,
  output logic          int_n,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          mem_inhibit
);
  seq_st_t       st_q, st_d;
  logic          ack_q, val_q;
  logic [IW-1:0] sel_q;
  logic          int_n_q, dout_en_q, inhib_q;
  logic [7:0]    dout_q;

  always_comb begin
    st_d  = st_q;
    clr_o = '0;
    unique case (st_q)
      ST_IDLE:   if (ack_c && !ack_q) st_d = ST_ACK;
      ST_ACK:    if (!ack_c) st_d = ST_WLO;
      ST_WLO:    if (fetch_c) st_d = ST_IDLE;
                 else if (mrd_c) st_d = ST_RLO;
      ST_RLO:    if (!mrd_c) st_d = ST_WHI;
      ST_WHI:    if (fetch_c) st_d = ST_IDLE;
                 else if (mrd_c) st_d = ST_RHI;
      ST_RHI:    if (!mrd_c) begin
                   st_d = ST_WFETCH;
                   if (val_q) clr_o[sel_q] = 1'b1;
                 end
      ST_WFETCH: if (fetch_c) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ack_q     <= 1'b0;
      sel_q     <= '0;
      val_q     <= 1'b0;
      int_n_q   <= 1'b1;
      dout_en_q <= 1'b0;
      dout_q    <= '0;
      inhib_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_c;
      if (st_q == ST_IDLE && st_d == ST_ACK) begin
        sel_q <= req_idx;
        val_q <= req_any;
      end
      int_n_q   <= !(req_any && st_d == ST_IDLE);
      dout_en_q <= (st_d == ST_ACK) || (st_d == ST_RLO) || (st_d == ST_RHI);
      inhib_q   <= (st_d == ST_WLO) || (st_d == ST_RLO) ||
                   (st_d == ST_WHI) || (st_d == ST_RHI);
      unique case (st_d)
        ST_ACK:  dout_q <= CALL_OP;
        ST_RLO:  dout_q <= vec_lo;
        ST_RHI:  dout_q <= vec_hi;
        default: dout_q <= '0;
      endcase
    end
  end

  assign sel_idx     = sel_q;
  assign int_n       = int_n_q;
  assign dout        = dout_q;
  assign dout_en     = dout_en_q;
  assign mem_inhibit = inhib_q;

  // R5
  ack_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && ack_c && !ack_q) |=> (dout_en_q && dout_q == CALL_OP));

  // R7
  inhibit_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RHI && !mrd_c) |=> (!inhib_q && !dout_en_q));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(sel_q));

  // R10
  fetch_release_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_c && st_q != ST_IDLE && st_q != ST_ACK) |=> (st_q == ST_IDLE && !inhib_q));
endmodule

// File: rtl/call_irq_ctrl.sv
module call_irq_ctrl #(
  parameter int         NUM_IRQ   = 8,
  parameter logic [7:0] PORT_BASE = 8'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [15:0]        addr,
  input  logic [7:0]         din,
  input  logic               m1_n,
  input  logic               iorq_n,
  input  logic               mreq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  output logic               int_n,
  output logic [7:0]         dout,
  output logic               dout_en,
  output logic               mem_inhibit
);
  localparam int IW       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int VEC_PORTS = 2 * NUM_IRQ;

  logic ack_c, mrd_c, fetch_c, iowr_c, iowr_q, iowr_go;
  logic [7:0] port_off;
  logic vec_we, en_we;
  logic [NUM_IRQ-1:0] en_wd, clr;
  logic req_any;
  logic [IW-1:0] req_idx, sel_idx, widx;
  logic [7:0] vec_lo, vec_hi;

  assign ack_c   = !m1_n && !iorq_n;
  assign fetch_c = !m1_n && !mreq_n;
  assign mrd_c   = m1_n && !mreq_n && !rd_n;
  assign iowr_c  = m1_n && !iorq_n && !wr_n;

  always_ff @(posedge clk) begin
    if (rst) iowr_q <= 1'b0;
    else     iowr_q <= iowr_c;
  end

  assign iowr_go  = iowr_c && !iowr_q;
  assign port_off = addr[7:0] - PORT_BASE;
  assign vec_we   = iowr_go && (32'(port_off) < VEC_PORTS);
  assign en_we    = iowr_go && (32'(port_off) == VEC_PORTS);
  assign widx     = IW'(port_off >> 1);

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) en_wd[i] = din[i];
  end

  cic_req_bank #(.N(NUM_IRQ), .IW(IW)) u_req (
    .clk(clk), .rst(rst), .irq_i(irq_in), .en_we(en_we), .en_wdata(en_wd),
    .clr_i(clr), .req_any(req_any), .req_idx(req_idx)
  );

  cic_vec_regs #(.N(NUM_IRQ), .IW(IW)) u_vec (
    .clk(clk), .we(vec_we), .we_hi(port_off[0]), .widx(widx), .wdata(din),
    .ridx(sel_idx), .rd_lo(vec_lo), .rd_hi(vec_hi)
  );

  cic_ack_seq #(.N(NUM_IRQ), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .ack_c(ack_c), .mrd_c(mrd_c), .fetch_c(fetch_c),
    .req_any(req_any), .req_idx(req_idx), .vec_lo(vec_lo), .vec_hi(vec_hi),
    .sel_idx(sel_idx), .clr_o(clr), .int_n(int_n), .dout(dout),
    .dout_en(dout_en), .mem_inhibit(mem_inhibit)
  );

  // R11
  io_write_once_chk: assert property (@(posedge clk) disable iff (rst)
    (iowr_c && iowr_q) |-> (!vec_we && !en_we));
endmodule

// File: tb/tb_call_irq_ctrl.sv
module tb_call_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic [15:0] addr = '0;
  logic [7:0] din = '0;
  logic m1_n = 1'b1, iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic int_n, dout_en, mem_inhibit;
  logic [7:0] dout;

  localparam logic [7:0] BASE = 8'h40;

  call_irq_ctrl #(.NUM_IRQ(8), .PORT_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .din(din),
    .m1_n(m1_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .int_n(int_n), .dout(dout), .dout_en(dout_en), .mem_inhibit(mem_inhibit)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // {request pattern, expected served input}
  localparam logic [7:0] TAB_PAT [15] = '{8'h04, 8'hA0, 8'h00, 8'h81, 8'h00,
    8'h42, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam int TAB_IDX [15] = '{2, 5, 7, 0, 7, 1, 6, 0, 1, 2, 3, 4, 5, 6, 7};

  function automatic logic [15:0] hv(int i);
    return {8'h80 + 8'(i), 8'(8'h10 * i + 5)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic io_wr(logic [7:0] port, logic [7:0] data);
    addr = {8'h00, port}; din = data; m1_n = 1'b1; iorq_n = 1'b0; wr_n = 1'b0;
    cyc(2);
    iorq_n = 1'b1; wr_n = 1'b1;
    cyc(1);
  endtask

  task automatic pulse_irq(logic [7:0] pat);
    irq_in = pat; cyc(1);
    irq_in = '0;  cyc(1);
  endtask

  task automatic run_ack(logic [15:0] vec, logic [7:0] late, logic [7:0] raise);
    chk(int_n == 1'b0, "R2", "int_n before ack", 16'(int_n), 16'h0);
    m1_n = 1'b0; iorq_n = 1'b0; cyc(1);
    chk(dout_en && dout == 8'hCD, "R5", "ack opcode", {7'h0, dout_en, dout}, 16'h01CD);
    chk(mem_inhibit == 1'b0, "R7", "inhibit in ack", 16'(mem_inhibit), 16'h0);
    cyc(1);
    chk(dout_en && dout == 8'hCD, "R5", "ack opcode held", {7'h0, dout_en, dout}, 16'h01CD);
    m1_n = 1'b1; iorq_n = 1'b1; cyc(1);
    chk(mem_inhibit && !dout_en, "R7", "inhibit after ack", {mem_inhibit, dout_en}, 16'h2);
    chk(int_n == 1'b1, "R10", "int_n while busy", 16'(int_n), 16'h1);
    mreq_n = 1'b0; rd_n = 1'b0; irq_in = late; cyc(1);
    irq_in = '0;
    chk(dout_en && dout == vec[7:0], "R6", "low byte", {7'h0, dout_en, dout}, {8'h01, vec[7:0]});
    chk(mem_inhibit == 1'b1, "R7", "inhibit low read", 16'(mem_inhibit), 16'h1);
    cyc(1);
    mreq_n = 1'b1; rd_n = 1'b1; cyc(1);
    chk(!dout_en && mem_inhibit, "R6", "gap between reads", {dout_en, mem_inhibit}, 16'h1);
    mreq_n = 1'b0; rd_n = 1'b0; cyc(1);
    chk(dout_en && dout == vec[15:8], "R6", "high byte", {7'h0, dout_en, dout}, {8'h01, vec[15:8]});
    cyc(1);
    mreq_n = 1'b1; rd_n = 1'b1; irq_in = raise; cyc(1);
    irq_in = '0;
    chk(!mem_inhibit && !dout_en, "R7", "release after reads", {mem_inhibit, dout_en}, 16'h0);
    chk(int_n == 1'b1, "R10", "int_n before fetch", 16'(int_n), 16'h1);
    mreq_n = 1'b0; wr_n = 1'b0; cyc(2);
    chk(!dout_en && !mem_inhibit, "R10", "stack write untouched", {dout_en, mem_inhibit}, 16'h0);
    mreq_n = 1'b1; wr_n = 1'b1; cyc(1);
    m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0; cyc(1);
    m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; cyc(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk(int_n == 1'b1, "R1", "int_n reset", 16'(int_n), 16'h1);
    chk(!dout_en && !mem_inhibit, "R1", "drive/inhibit reset", {dout_en, mem_inhibit}, 16'h0);
    rst = 1'b0; cyc(1);

    // R3 all inputs disabled after reset
    pulse_irq(8'h08);
    chk(int_n == 1'b1, "R3", "disabled after reset", 16'(int_n), 16'h1);
    // R11 load handler bytes
    for (int i = 0; i < 8; i++) begin
      io_wr(BASE + 8'(2 * i), hv(i)[7:0]);
      io_wr(BASE + 8'(2 * i + 1), hv(i)[15:8]);
    end
    io_wr(BASE + 8'd16, 8'hF7);
    chk(int_n == 1'b1, "R3", "input 3 masked", 16'(int_n), 16'h1);
    io_wr(BASE + 8'd16, 8'hFF);
    chk(int_n == 1'b0, "R3", "held request after enable", 16'(int_n), 16'h0);
    run_ack(hv(3), 8'h00, 8'h00);

    // R4 priority table
    for (int k = 0; k < 15; k++) begin
      if (TAB_PAT[k] != 8'h00) pulse_irq(TAB_PAT[k]);
      run_ack(hv(TAB_IDX[k]), 8'h00, 8'h00);
    end
    chk(int_n == 1'b1, "R4", "all served", 16'(int_n), 16'h1);

    // R8 higher priority request arriving after ack start
    pulse_irq(8'h20);
    run_ack(hv(5), 8'h01, 8'h00);
    chk(int_n == 1'b0, "R8", "late request pending", 16'(int_n), 16'h0);
    run_ack(hv(0), 8'h00, 8'h00);

    // R9 new edge on served input in the clearing cycle
    pulse_irq(8'h10);
    run_ack(hv(4), 8'h00, 8'h10);
    chk(int_n == 1'b0, "R9", "re-request kept", 16'(int_n), 16'h0);
    run_ack(hv(4), 8'h00, 8'h00);
    chk(int_n == 1'b1, "R9", "cleared after service", 16'(int_n), 16'h0001);

    // R11 high byte write leaves low byte
    io_wr(BASE + 8'd5, 8'hEE);
    pulse_irq(8'h04);
    run_ack({8'hEE, hv(2)[7:0]}, 8'h00, 8'h00);

    finish_run();
  end
endmodule